// File: doc/BRIEF.md
# Pulse-Interval Frame Receiver

This block sits on the card side of a contactless link. Its input is the demodulated carrier envelope. The reader sends each bit as a short pause in the carrier, and the bit value is carried by how far apart the pauses are. The block turns these pauses back into frames.

It finds every rising edge of the envelope and measures the number of ticks since the previous rising edge. It sorts that interval into three classes: a one, a zero, or a bad interval. Good bits are packed into a frame word with the first bit in the lowest position. A frame ends in one of two ways: a bad interval arrives, or the line stays quiet for longer than the longest legal bit. When a frame ends, the block hands it to the protocol logic with a one-cycle strobe and its bit count. Frames of four bits or fewer are treated as noise and thrown away. The lengths that carry meaning for the protocol logic are 6, 7, 11 and 23 bits.

The controller has three states:
- `S_IDLE`: no frame is open. A good interval moves it to `S_COLLECT` (transition *open*). A bad interval leaves it in `S_IDLE` (transition *ignore*).
- `S_COLLECT`: bits are being gathered. A good interval keeps it here (*append*). A bad interval or a silence timeout ends the frame. If the frame holds more than four bits, the controller goes to `S_DELIVER` (*close*). Otherwise it returns to `S_IDLE` (*drop*).
- `S_DELIVER`: lasts one cycle, presents the frame, clears the accumulator and returns to `S_IDLE` (*release*).

Top module: `pulse_frame_rx`

## Requirements
- R1: After reset, `frame_valid` is 0, and `frame_data` and `frame_len` are 0.
- R2: An interval of strictly more than 130 and strictly less than 170 ticks decodes as a 1 bit. An interval of exactly 130 or exactly 170 is a bad interval.
- R3: An interval of strictly more than 70 and strictly less than 110 ticks decodes as a 0 bit. An interval of exactly 70 or exactly 110 is a bad interval.
- R4: Bits are stored in arrival order. The first bit goes to `frame_data[0]`. `frame_len` gives the number of bits stored, and unused high bits of `frame_data` are 0.
- R5: A bad interval while a frame is open ends that frame. The bit for that edge is not stored. A good interval that follows opens a new frame.
- R6: A bad interval while no frame is open has no effect. No frame opens and no strobe is produced.
- R7: If no rising edge arrives for 170 ticks after the last bit of an open frame, the frame ends. With one tick per clock, the strobe comes 170 to 176 cycles after the last edge at the input.
- R8: A frame of 4 bits or fewer is discarded with no strobe. A frame of 5 bits or more is delivered.
- R9: At most 31 bits are kept. Further bits of the same frame are dropped, and `frame_len` stays at 31.
- R10: `frame_valid` is a single-cycle pulse. While it is low, `frame_data` and `frame_len` are 0.
- R11: The interval counter saturates at 3000 ticks (20 times the 1-bit spacing) and restarts on the next rising edge. However long the silence, it never decodes as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| env_in | input | 1 | Demodulated envelope, asynchronous, synchronised inside |
| frame_valid | output | 1 | One-cycle strobe when a frame is delivered |
| frame_data | output | 31 | Frame bits, first received bit in bit 0 |
| frame_len | output | 5 | Number of bits in the delivered frame |

## Verification
The bench places edges exactly on and just inside each tolerance bound. A design with a non-strict compare would pack an extra bit, and one with a narrow window would split the frame. It checks that a bad interval splits an open frame but does nothing while the line is idle, and that four-bit frames disappear while five-bit frames appear. It sends over-long frames to catch an accumulator that wraps or overwrites bit 0. A silence longer than the counter range, followed by an edge, exposes a counter that wraps instead of saturating: such a counter would decode a phantom 1 bit.

// File: rtl/prf_pkg.sv
`timescale 1ns/1ps
package prf_pkg;
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_BAD  = 2'd2
    } sym_t;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_COLLECT = 2'd1,
        S_DELIVER = 2'd2
    } rx_state_t;
endpackage

// File: rtl/prf_edge_sync.sv
`timescale 1ns/1ps
module prf_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], async_in};
    end

    // sh_q[1] is the second synchroniser stage, sh_q[2] its delayed copy
    assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/prf_interval_timer.sv
`timescale 1ns/1ps
module prf_interval_timer #(
    parameter int CNT_W    = 12,
    parameter int LIMIT    = 3000,
    parameter int TICK_DIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);
    logic tick;

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam int DIV_W = $clog2(TICK_DIV);
            localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(TICK_DIV - 1);
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (!rst_n || restart || div_q == DIV_TOP) div_q <= '0;
                else                                       div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DIV_TOP);
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    // Counter parks at LIMIT (stopped) until the next edge restarts it
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= LIM_C;
        else if (restart)             cnt <= CNT_W'(1);
        else if (tick && cnt < LIM_C) cnt <= cnt + 1'b1;
    end

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM_C);
    p_cnt_park_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LIM_C && !restart) |=> cnt == LIM_C);
endmodule

// File: rtl/prf_classify.sv
`timescale 1ns/1ps
module prf_classify
    import prf_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int ONE_TICKS = 150,
    parameter int ZERO_TICKS = 90,
    parameter int FUZZ      = 20
) (
    input  logic [CNT_W-1:0] interval,
    output sym_t             sym
);
    localparam logic [CNT_W-1:0] ONE_LO  = CNT_W'(ONE_TICKS - FUZZ);
    localparam logic [CNT_W-1:0] ONE_HI  = CNT_W'(ONE_TICKS + FUZZ);
    localparam logic [CNT_W-1:0] ZERO_LO = CNT_W'(ZERO_TICKS - FUZZ);
    localparam logic [CNT_W-1:0] ZERO_HI = CNT_W'(ZERO_TICKS + FUZZ);

    always_comb begin
        if (interval > ONE_LO && interval < ONE_HI)        sym = SYM_ONE;
        else if (interval > ZERO_LO && interval < ZERO_HI) sym = SYM_ZERO;
        else                                               sym = SYM_BAD;
    end
endmodule

// File: rtl/pulse_frame_rx.sv
`timescale 1ns/1ps
module pulse_frame_rx
    import prf_pkg::*;
#(
    parameter int ONE_TICKS  = 150,
    parameter int ZERO_TICKS = 90,
    parameter int FUZZ       = 20,
    parameter int STOP_MULT  = 20,
    parameter int MAX_BITS   = 31,
    parameter int NOISE_BITS = 4,
    parameter int TICK_DIV   = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        env_in,
    output logic                        frame_valid,
    output logic [MAX_BITS-1:0]         frame_data,
    output logic [$clog2(MAX_BITS+1)-1:0] frame_len
);
    localparam int LIMIT = STOP_MULT * ONE_TICKS;
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam int LEN_W = $clog2(MAX_BITS + 1);
    localparam logic [CNT_W-1:0] END_C   = CNT_W'(ONE_TICKS + FUZZ);
    localparam logic [LEN_W-1:0] MAX_C   = LEN_W'(MAX_BITS);
    localparam logic [LEN_W-1:0] NOISE_C = LEN_W'(NOISE_BITS);

    logic             rise;
    logic [CNT_W-1:0] cnt;
    sym_t             sym;
    rx_state_t        state_q, state_d;
    logic [MAX_BITS-1:0] data_q;
    logic [LEN_W-1:0]    len_q;
    logic take_bit, frame_end;

    prf_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (env_in),
        .rise     (rise)
    );

    prf_interval_timer #(
        .CNT_W    (CNT_W),
        .LIMIT    (LIMIT),
        .TICK_DIV (TICK_DIV)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rise),
        .cnt     (cnt)
    );

    prf_classify #(
        .CNT_W      (CNT_W),
        .ONE_TICKS  (ONE_TICKS),
        .ZERO_TICKS (ZERO_TICKS),
        .FUZZ       (FUZZ)
    ) u_class (
        .interval (cnt),
        .sym      (sym)
    );

    assign take_bit  = rise && (sym != SYM_BAD) && (state_q != S_DELIVER);
    assign frame_end = (state_q == S_COLLECT) &&
                       ((rise && sym == SYM_BAD) || (!rise && cnt >= END_C));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (take_bit) state_d = S_COLLECT;
            S_COLLECT: if (frame_end)
                           state_d = (len_q > NOISE_C) ? S_DELIVER : S_IDLE;
            S_DELIVER: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Bit accumulator
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == S_DELIVER || (frame_end && state_d == S_IDLE)) begin
            data_q <= '0;
            len_q  <= '0;
        end else if (take_bit && len_q < MAX_C) begin
            data_q[len_q] <= (sym == SYM_ONE);
            len_q         <= len_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        frame_valid = (state_q == S_DELIVER);
        frame_data  = frame_valid ? data_q : '0;
        frame_len   = frame_valid ? len_q  : '0;
    end

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    p_noise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> frame_len > NOISE_C);
    p_len_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= MAX_C);
    p_idle_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && rise && sym == SYM_BAD) |=> (state_q == S_IDLE && len_q == '0));
    p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COLLECT && !rise && cnt >= END_C) |=> state_q != S_COLLECT);
    p_bad_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COLLECT && rise && sym == SYM_BAD) |=> $stable(len_q) || len_q == '0);
endmodule

// File: tb/pulse_frame_rx_test.sv
`timescale 1ns/1ps
module pulse_frame_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        env = 1'b0;
    logic        frame_valid;
    logic [30:0] frame_data;
    logic [4:0]  frame_len;

    int checks = 0;
    int errors = 0;
    int got_cnt = 0;
    int pulse_viol = 0;
    int zero_viol = 0;
    logic        prev_valid = 1'b0;
    logic [30:0] rec_data [0:63];
    logic [4:0]  rec_len  [0:63];
    bit done = 1'b0;

    localparam int PAUSE = 10;

    always #10 clk = ~clk;

    pulse_frame_rx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .env_in      (env),
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .frame_len   (frame_len)
    );

    // Frame monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) begin
                rec_data[got_cnt % 64] = frame_data;
                rec_len[got_cnt % 64]  = frame_len;
                got_cnt++;
                if (prev_valid) pulse_viol++;
            end else if (frame_data != 0 || frame_len != 0) begin
                zero_viol++;
            end
            prev_valid = frame_valid;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // next rising edge exactly n cycles after the previous one
    task automatic gap(input int n);
        repeat (n - PAUSE) @(negedge clk);
        env = 1'b0;
        repeat (PAUSE) @(negedge clk);
        env = 1'b1;
    endtask

    task automatic send_bits(input logic [39:0] b, input int n, input bit jit);
        for (int i = 0; i < n; i++) begin
            int nom;
            nom = b[i] ? 150 : 90;
            if (jit) nom = nom + int'($urandom_range(0, 38)) - 19;
            gap(nom);
        end
    endtask

    task automatic quiet();
        repeat (400) @(negedge clk);
    endtask

    function automatic logic [30:0] exp_word(input logic [39:0] b, input int n);
        logic [30:0] w;
        w = '0;
        for (int i = 0; i < n && i < 31; i++) w[i] = b[i];
        return w;
    endfunction

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        int lat;
        void'($urandom(32'd24680));
        repeat (5) @(negedge clk);
        chk("R1 valid in reset", frame_valid, 0);
        rst_n = 1'b1;
        env = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 data after reset", frame_data, 0);
        chk("R1 len after reset", frame_len, 0);

        // R2 lower bound 130 splits an open frame
        base = got_cnt;
        gap(300); send_bits(40'h3F, 6, 0); gap(130); send_bits(40'h1F, 5, 0); quiet();
        chk("R2 frames at 130", got_cnt - base, 2);
        chk("R2 first len", rec_len[base % 64], 6);
        chk("R5 second frame", rec_data[(base + 1) % 64], 31'h1F);

        // R2 upper bound 170
        base = got_cnt;
        gap(300); send_bits(40'h3F, 6, 0); gap(170); send_bits(40'h1F, 5, 0); quiet();
        chk("R2 frames at 170", got_cnt - base, 2);
        chk("R2 first data", rec_data[base % 64], 31'h3F);

        // R3 bounds 70 and 110, the latter while idle
        base = got_cnt;
        gap(300); send_bits(40'h2A, 6, 0); gap(70); gap(110); send_bits(40'h00, 5, 0); quiet();
        chk("R3 frames", got_cnt - base, 2);
        chk("R3 zero/one mix", rec_data[base % 64], 31'h2A);
        chk("R3 zeros len", rec_len[(base + 1) % 64], 5);

        // R6 bad intervals while idle
        base = got_cnt;
        gap(300); gap(50); gap(200); gap(300); quiet();
        chk("R6 idle bad intervals", got_cnt - base, 0);

        // R8 noise threshold
        base = got_cnt;
        gap(300); send_bits(40'hF, 4, 0); quiet();
        chk("R8 four bits dropped", got_cnt - base, 0);
        gap(300); send_bits(40'h15, 5, 0); quiet();
        chk("R8 five bits kept", got_cnt - base, 1);
        chk("R8 five bit data", rec_data[base % 64], 31'h15);

        // R9 overflow
        base = got_cnt;
        gap(300); send_bits(40'hFF_FFFF_FFFF, 34, 0); quiet();
        chk("R9 len capped", rec_len[base % 64], 31);
        chk("R9 data", rec_data[base % 64], 31'h7FFF_FFFF);

        // R7 timeout latency
        base = got_cnt;
        gap(300); send_bits(40'h55, 7, 0);
        lat = 0;
        while (!frame_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        chk("R7 latency in window", (lat >= 170 && lat <= 176), 1);
        quiet();
        chk("R7 frame data", rec_data[base % 64], 31'h55);

        // R11 long silence must not wrap into a bit
        base = got_cnt;
        gap(300); gap(4246); send_bits(40'h1F, 5, 0); quiet();
        chk("R11 len after long silence", rec_len[base % 64], 5);

        // R4 random frames with jitter
        for (int f = 0; f < 16; f++) begin
            logic [39:0] b;
            int n;
            n = $urandom_range(1, 34);
            b = {$urandom, $urandom};
            base = got_cnt;
            gap(300); send_bits(b, n, 1); quiet();
            if (n <= 4) begin
                chk("R8 random noise", got_cnt - base, 0);
            end else begin
                chk("R4 random count", got_cnt - base, 1);
                chk("R4 random data", rec_data[base % 64], exp_word(b, n));
                chk("R4 random len", rec_len[base % 64], (n > 31) ? 31 : n);
            end
        end

        chk("R10 single-cycle strobe", pulse_viol, 0);
        chk("R10 zero outputs when idle", zero_viol, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule